// File: doc/BRIEF.md
# Power converter supervisory sequencer

This block is the top-level sequencer of a switching power controller. It receives
digital comparator results on the supply level (start level reached, below
undervoltage, below burst threshold, below latch-reset level), the mains and
external-temperature qualification results, a zero-duty request from the control
loop, and two groups of protection requests. From these it decides whether the
converter is powered down, qualifying a start, ramping up, switching normally,
waiting out a restart, or locked off.

Protection requests fall into two classes. A restart-class request stops switching
and lets the supply discharge to the undervoltage level, after which the normal
start sequence repeats. A lock-off-class request stops switching and holds the
converter off until the supply collapses below the much lower latch-reset level.
An undervoltage seen while switching is handled as lock-off. While switching with a
zero-duty request and a supply below the burst threshold, the block asks the gate
driver for exactly two recharge pulses.

Top module: `pwr_supervisor`

## Requirements
- R1: After synchronous reset `sw_en`, `ss_level` and `burst_req` are all 0, and `ss_level` is 0 in every cycle that `sw_en` is 0.
- R2: From power-down, `vcc_at_start` moves the block to a qualifying state; switching (`sw_en`=1) begins on the clock edge at which `mains_ok` and `temp_ok` are both 1 in that state, and never while either is 0.
- R3: `ss_level` is 0 when switching starts and rises by exactly one every `TICK_DIV` clock cycles; normal running begins on the edge where it reaches its all-ones value, which it then holds.
- R4: A restart-class request while switching clears `sw_en` on the next edge; the start level is ignored until `vcc_below_uvlo` returns the block to power-down, after which the start sequence runs again.
- R5: A lock-off-class request in any state except power-down and lock-off clears `sw_en` on the next edge; the block then ignores the start and undervoltage flags until `vcc_below_latch_rst`, which returns it to power-down.
- R6: `vcc_below_uvlo` while switching leads to lock-off, not to a restart.
- R7: When restart-class and lock-off-class requests arrive in the same cycle, lock-off is taken.
- R8: While running with `zero_duty`=1 and `vcc_below_burst`=1, `burst_req` gives exactly two high pulses of `PULSE_W` cycles separated by `GAP_W` low cycles; no further pulses follow until `vcc_below_burst` has gone low, and nothing is issued without `zero_duty`.
- R9: Lock-off-class requests in power-down have no effect: a later start proceeds normally.
- R10: Leaving the running state aborts a burst: `burst_req` is 0 from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vcc_at_start | input | 1 | Supply has reached the start level |
| vcc_below_uvlo | input | 1 | Supply is below the undervoltage level |
| vcc_below_burst | input | 1 | Supply is below the burst threshold |
| vcc_below_latch_rst | input | 1 | Supply is below the lock-off release level |
| mains_ok | input | 1 | Mains current above the brown-in level |
| temp_ok | input | 1 | External temperature sense above its detection level |
| zero_duty | input | 1 | Control loop requests zero duty |
| restart_req | input | N_RESTART | Restart-class protection requests (brownout, max duty) |
| latch_req | input | N_LATCH | Lock-off-class protection requests |
| sw_en | output | 1 | Switching enable to the modulator |
| ss_level | output | SS_W | Soft-start limit on the peak current, 0 to full scale |
| burst_req | output | 1 | Recharge pulse request to the gate driver |

## Verification
The two functions that can collide in one cycle are the restart path and the
lock-off path: a restart request and a lock-off request are raised on the same
edge during soft-start, then the undervoltage and start flags are driven as they
would be in a restart. The outcome is judged by the absence of switching after that
sequence, which only a lock-off explains, and by recovery after the latch-reset flag.
A second overlap, a burst in progress when a restart fault arrives, is provoked
mid-pulse and judged by `burst_req` dropping on the next edge.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  typedef enum logic [2:0] {
    ST_PDOWN = 3'd0,
    ST_CHECK = 3'd1,
    ST_SOFT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_RWAIT = 3'd4,
    ST_LATCH = 3'd5
  } sup_state_e;

  typedef enum logic [2:0] {
    BP_IDLE = 3'd0,
    BP_PUL1 = 3'd1,
    BP_GAP  = 3'd2,
    BP_PUL2 = 3'd3,
    BP_HOLD = 3'd4
  } burst_ph_e;

  // States in which the gate is allowed to switch.
  function automatic logic st_switching(sup_state_e s);
    return (s == ST_SOFT) || (s == ST_RUN);
  endfunction

  // States in which lock-off requests are acted upon.
  function automatic logic st_guarded(sup_state_e s);
    return (s != ST_PDOWN) && (s != ST_LATCH);
  endfunction

  // Bits needed to hold the values 0..maxv.
  function automatic int unsigned cnt_bits(int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwr_fault_merge.sv
module pwr_fault_merge #(
  parameter int unsigned N_RESTART = 2,
  parameter int unsigned N_LATCH   = 5
) (
  input  logic [N_RESTART-1:0] restart_req,
  input  logic [N_LATCH-1:0]   latch_req,
  input  logic                 vcc_below_uvlo,
  input  logic                 sw_active,
  input  logic                 guarded,
  output logic                 latch_hit,
  output logic                 restart_hit
);

  logic any_latch;
  logic any_restart;
  logic uvlo_fault;

  assign any_latch   = |latch_req;
  assign any_restart = |restart_req;
  // An undervoltage while switching is a lock-off fault, never a restart.
  assign uvlo_fault  = sw_active & vcc_below_uvlo;

  assign latch_hit   = (guarded & any_latch) | uvlo_fault;
  // Lock-off wins over restart in the same cycle.
  assign restart_hit = sw_active & any_restart & ~latch_hit;

endmodule

// File: rtl/pwr_ss_ramp.sv
module pwr_ss_ramp #(
  parameter int unsigned TICK_DIV = 2745,
  parameter int unsigned SS_W     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic            keep,
  output logic            ramp_last,
  output logic [SS_W-1:0] ss_level
);

  import pwr_sup_pkg::*;

  localparam int unsigned PW = cnt_bits(TICK_DIV);
  localparam logic [PW-1:0]   PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [SS_W-1:0] SS_PENULT = {{(SS_W-1){1'b1}}, 1'b0};

  logic [PW-1:0] pre_q;
  logic          tick;

  assign tick      = advance && (pre_q == PRE_LAST);
  assign ramp_last = tick && (ss_level == SS_PENULT);

  always_ff @(posedge clk) begin
    if (rst || !keep) begin
      pre_q    <= '0;
      ss_level <= '0;
    end else if (advance) begin
      if (tick) begin
        pre_q    <= '0;
        ss_level <= ss_level + SS_W'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

endmodule

// File: rtl/pwr_burst_gen.sv
module pwr_burst_gen #(
  parameter int unsigned PULSE_W = 40,
  parameter int unsigned GAP_W   = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic zero_duty,
  input  logic below_burst,
  output logic burst_req
);

  import pwr_sup_pkg::*;

  localparam int unsigned CW = cnt_bits(max2(PULSE_W, GAP_W));
  localparam logic [CW-1:0] PUL_LAST = CW'(PULSE_W - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_W - 1);

  burst_ph_e     ph_q;
  logic [CW-1:0] cnt_q;
  logic          trig;

  assign trig      = zero_duty & below_burst;
  assign burst_req = (ph_q == BP_PUL1) || (ph_q == BP_PUL2);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph_q  <= BP_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        BP_IDLE: begin
          cnt_q <= '0;
          if (trig) ph_q <= BP_PUL1;
        end
        BP_PUL1: begin
          if (cnt_q == PUL_LAST) begin
            ph_q  <= BP_GAP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        BP_GAP: begin
          if (cnt_q == GAP_LAST) begin
            ph_q  <= BP_PUL2;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        BP_PUL2: begin
          if (cnt_q == PUL_LAST) begin
            ph_q  <= BP_HOLD;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        BP_HOLD: begin
          if (!below_burst) ph_q <= BP_IDLE;
        end
        default: begin
          ph_q  <= BP_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int unsigned TICK_DIV  = 2745,
  parameter int unsigned SS_W      = 8,
  parameter int unsigned N_RESTART = 2,
  parameter int unsigned N_LATCH   = 5,
  parameter int unsigned PULSE_W   = 40,
  parameter int unsigned GAP_W     = 200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vcc_at_start,
  input  logic                 vcc_below_uvlo,
  input  logic                 vcc_below_burst,
  input  logic                 vcc_below_latch_rst,
  input  logic                 mains_ok,
  input  logic                 temp_ok,
  input  logic                 zero_duty,
  input  logic [N_RESTART-1:0] restart_req,
  input  logic [N_LATCH-1:0]   latch_req,
  output logic                 sw_en,
  output logic [SS_W-1:0]      ss_level,
  output logic                 burst_req
);

  import pwr_sup_pkg::*;

  sup_state_e state_q;
  sup_state_e state_d;

  logic latch_hit;
  logic restart_hit;
  logic ramp_last;
  logic sw_now;
  logic sw_next;
  logic burst_en;

  assign sw_now   = st_switching(state_q);
  assign sw_next  = st_switching(state_d);
  assign burst_en = (state_q == ST_RUN) && (state_d == ST_RUN);
  assign sw_en    = sw_now;

  pwr_fault_merge #(
    .N_RESTART(N_RESTART),
    .N_LATCH  (N_LATCH)
  ) u_faults (
    .restart_req   (restart_req),
    .latch_req     (latch_req),
    .vcc_below_uvlo(vcc_below_uvlo),
    .sw_active     (sw_now),
    .guarded       (st_guarded(state_q)),
    .latch_hit     (latch_hit),
    .restart_hit   (restart_hit)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PDOWN: begin
        if (vcc_at_start) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (latch_hit)                state_d = ST_LATCH;
        else if (vcc_below_uvlo)      state_d = ST_PDOWN;
        else if (mains_ok && temp_ok) state_d = ST_SOFT;
      end
      ST_SOFT: begin
        if (latch_hit)        state_d = ST_LATCH;
        else if (restart_hit) state_d = ST_RWAIT;
        else if (ramp_last)   state_d = ST_RUN;
      end
      ST_RUN: begin
        if (latch_hit)        state_d = ST_LATCH;
        else if (restart_hit) state_d = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (latch_hit)           state_d = ST_LATCH;
        else if (vcc_below_uvlo) state_d = ST_PDOWN;
      end
      ST_LATCH: begin
        if (vcc_below_latch_rst) state_d = ST_PDOWN;
      end
      default: state_d = ST_PDOWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_PDOWN;
    else     state_q <= state_d;
  end

  pwr_ss_ramp #(
    .TICK_DIV(TICK_DIV),
    .SS_W    (SS_W)
  ) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .advance  (state_q == ST_SOFT),
    .keep     (sw_next),
    .ramp_last(ramp_last),
    .ss_level (ss_level)
  );

  pwr_burst_gen #(
    .PULSE_W(PULSE_W),
    .GAP_W  (GAP_W)
  ) u_burst (
    .clk        (clk),
    .rst        (rst),
    .en         (burst_en),
    .zero_duty  (zero_duty),
    .below_burst(vcc_below_burst),
    .burst_req  (burst_req)
  );

endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
  parameter int unsigned SS_W      = 8,
  parameter int unsigned N_RESTART = 2,
  parameter int unsigned N_LATCH   = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sw_en,
  input logic [SS_W-1:0]         ss_level,
  input logic                    burst_req,
  input pwr_sup_pkg::sup_state_e state_q,
  input logic                    latch_hit,
  input logic                    restart_hit,
  input logic [N_RESTART-1:0]    restart_req,
  input logic [N_LATCH-1:0]      latch_req,
  input logic                    vcc_below_uvlo,
  input logic                    vcc_below_latch_rst
);

  import pwr_sup_pkg::*;

  localparam logic [SS_W-1:0] SS_FULL = '1;

  // R1
  ss_zero_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_en |-> (ss_level == '0));

  // R3
  ss_run_full_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (ss_level == SS_FULL));

  // R3
  ss_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SOFT) && ($past(state_q) == ST_SOFT)) |->
      ((ss_level == $past(ss_level)) || (ss_level == $past(ss_level) + SS_W'(1))));

  // R4
  restart_wait_chk: assert property (@(posedge clk) disable iff (rst)
    restart_hit |=> (state_q == ST_RWAIT) && !sw_en);

  // R5
  latch_off_chk: assert property (@(posedge clk) disable iff (rst)
    latch_hit |=> (state_q == ST_LATCH) && !sw_en);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_LATCH) && !vcc_below_latch_rst) |=> (state_q == ST_LATCH));

  // R6
  uvlo_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_en && vcc_below_uvlo) |=> (state_q == ST_LATCH));

  // R7
  latch_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_en && (|latch_req) && (|restart_req)) |=> (state_q == ST_LATCH));

  // R8
  burst_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    burst_req |-> (state_q == ST_RUN) && sw_en);

endmodule

bind pwr_supervisor pwr_supervisor_chk #(
  .SS_W     (SS_W),
  .N_RESTART(N_RESTART),
  .N_LATCH  (N_LATCH)
) u_chk (
  .clk                (clk),
  .rst                (rst),
  .sw_en              (sw_en),
  .ss_level           (ss_level),
  .burst_req          (burst_req),
  .state_q            (state_q),
  .latch_hit          (latch_hit),
  .restart_hit        (restart_hit),
  .restart_req        (restart_req),
  .latch_req          (latch_req),
  .vcc_below_uvlo     (vcc_below_uvlo),
  .vcc_below_latch_rst(vcc_below_latch_rst)
);

// File: tb/tb_pwr_supervisor.sv
`timescale 1ns/100ps
module tb_pwr_supervisor;

  localparam int DIV   = 4;
  localparam int PW    = 3;
  localparam int GW    = 5;
  localparam int NR    = 2;
  localparam int NL    = 5;
  localparam int SSW   = 8;
  localparam int SSTOP = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_at_start = 0, vcc_below_uvlo = 0, vcc_below_burst = 0, vcc_below_latch_rst = 0;
  logic mains_ok = 0, temp_ok = 0, zero_duty = 0;
  logic [NR-1:0] restart_req = '0;
  logic [NL-1:0] latch_req = '0;
  logic sw_en, burst_req;
  logic [SSW-1:0] ss_level;

  always #2.5 clk = ~clk;

  pwr_supervisor #(
    .TICK_DIV(DIV), .SS_W(SSW), .N_RESTART(NR), .N_LATCH(NL), .PULSE_W(PW), .GAP_W(GW)
  ) dut (
    .clk(clk), .rst(rst), .vcc_at_start(vcc_at_start), .vcc_below_uvlo(vcc_below_uvlo),
    .vcc_below_burst(vcc_below_burst), .vcc_below_latch_rst(vcc_below_latch_rst),
    .mains_ok(mains_ok), .temp_ok(temp_ok), .zero_duty(zero_duty),
    .restart_req(restart_req), .latch_req(latch_req),
    .sw_en(sw_en), .ss_level(ss_level), .burst_req(burst_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference: mode 0 off, 1 qualify, 2 ramp, 3 run, 4 wait restart, 5 locked.
  int mode = 0, lvl = 0, sub = 0, bph = 0, bcnt = 0;

  always @(posedge clk) begin : ref_model
    int nxt;
    bit on, lock, rs;
    if (rst) begin
      mode = 0; lvl = 0; sub = 0; bph = 0; bcnt = 0;
    end else begin
      on   = (mode == 2) || (mode == 3);
      lock = ((mode != 0) && (mode != 5) && (latch_req != 0)) || (on && vcc_below_uvlo);
      rs   = on && (restart_req != 0) && !lock;
      nxt  = mode;
      if (mode == 0 && vcc_at_start) nxt = 1;
      else if (mode == 1) begin
        if (lock) nxt = 5;
        else if (vcc_below_uvlo) nxt = 0;
        else if (mains_ok && temp_ok) nxt = 2;
      end else if (mode == 2 || mode == 3) begin
        if (lock) nxt = 5;
        else if (rs) nxt = 4;
      end else if (mode == 4) begin
        if (lock) nxt = 5;
        else if (vcc_below_uvlo) nxt = 0;
      end else if (mode == 5 && vcc_below_latch_rst) nxt = 0;
      if (mode == 2 && nxt == 2) begin
        sub++;
        if (sub == DIV) begin
          sub = 0;
          lvl++;
          if (lvl == SSTOP) nxt = 3;
        end
      end
      if (nxt != 2 && nxt != 3) begin
        lvl = 0; sub = 0;
      end
      if (!(mode == 3 && nxt == 3)) begin
        bph = 0; bcnt = 0;
      end else begin
        case (bph)
          0: if (zero_duty && vcc_below_burst) begin bph = 1; bcnt = 0; end
          1, 3: begin
            bcnt++;
            if (bcnt == PW) begin bph++; bcnt = 0; end
          end
          2: begin
            bcnt++;
            if (bcnt == GW) begin bph = 3; bcnt = 0; end
          end
          default: if (!vcc_below_burst) bph = 0;
        endcase
      end
      mode = nxt;
    end
  end

  always @(negedge clk) begin
    bit e_sw, e_b;
    if (!done) begin
      e_sw = (mode == 2) || (mode == 3);
      e_b  = (bph == 1) || (bph == 3);
      checks++;
      if (sw_en !== e_sw || int'(ss_level) != lvl || burst_req !== e_b) begin
        errors++;
        $display("FAIL %s: per-cycle model, actual sw=%0b ss=%0d burst=%0b expected sw=%0b ss=%0d burst=%0b",
                 tag, sw_en, ss_level, burst_req, e_sw, lvl, e_b);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_eq(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic count_pulses(input int cycles, output int n);
    logic prev;
    n = 0;
    prev = burst_req;
    for (int i = 0; i < cycles; i++) begin
      step(1);
      if (burst_req && !prev) n++;
      prev = burst_req;
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual run still active, expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int np;
    step(4);
    rst = 1'b0;
    step(1);
    // R1 reset state
    tag = "R1";
    expect_eq("R1", "sw_en after reset", sw_en, 0);
    expect_eq("R1", "ss_level after reset", ss_level, 0);
    expect_eq("R1", "burst_req after reset", burst_req, 0);

    // R9 lock-off requests while powered down are ignored
    tag = "R9";
    latch_req = 5'b00001;
    step(5);
    expect_eq("R9", "sw_en with lock request in power-down", sw_en, 0);
    latch_req = '0;

    // R2 start qualification
    tag = "R2";
    vcc_at_start = 1; temp_ok = 1; mains_ok = 0;
    step(6);
    expect_eq("R2", "sw_en with mains low", sw_en, 0);
    mains_ok = 1; temp_ok = 0;
    step(5);
    expect_eq("R2", "sw_en with temperature low", sw_en, 0);
    temp_ok = 1;
    step(1);
    expect_eq("R2", "sw_en after qualification", sw_en, 1);
    vcc_at_start = 0;

    // R3 soft-start ramp
    tag = "R3";
    expect_eq("R3", "ss_level at ramp entry", ss_level, 0);
    step(DIV);
    expect_eq("R3", "ss_level after one tick", ss_level, 1);
    step(DIV * 253);
    expect_eq("R3", "ss_level one step below top", ss_level, 254);
    step(DIV);
    expect_eq("R3", "ss_level at top", ss_level, 255);
    step(20);
    expect_eq("R3", "ss_level held in run", ss_level, 255);

    // R8 two recharge pulses
    tag = "R8";
    zero_duty = 1; vcc_below_burst = 1;
    count_pulses(30, np);
    expect_eq("R8", "pulses in first burst", np, 2);
    count_pulses(20, np);
    expect_eq("R8", "pulses while threshold stays low", np, 0);
    vcc_below_burst = 0;
    step(2);
    vcc_below_burst = 1;
    count_pulses(30, np);
    expect_eq("R8", "pulses after rearm", np, 2);
    vcc_below_burst = 0; zero_duty = 0;
    step(2);
    vcc_below_burst = 1;
    count_pulses(20, np);
    expect_eq("R8", "pulses without zero duty", np, 0);
    vcc_below_burst = 0;
    step(2);

    // R10 burst aborted by a restart fault
    tag = "R10";
    zero_duty = 1; vcc_below_burst = 1;
    step(2);
    expect_eq("R10", "burst_req mid pulse", burst_req, 1);
    restart_req = 2'b10;
    step(1);
    expect_eq("R10", "burst_req after leaving run", burst_req, 0);
    restart_req = '0; zero_duty = 0; vcc_below_burst = 0;

    // R4 restart cycle
    tag = "R4";
    expect_eq("R4", "sw_en after restart fault", sw_en, 0);
    vcc_at_start = 1;
    step(5);
    expect_eq("R4", "sw_en with start level before undervoltage", sw_en, 0);
    vcc_at_start = 0; vcc_below_uvlo = 1;
    step(1);
    vcc_below_uvlo = 0; vcc_at_start = 1;
    step(2);
    expect_eq("R4", "sw_en after recharge", sw_en, 1);
    expect_eq("R3", "ss_level restarts from zero", ss_level, 0);
    vcc_at_start = 0;

    // R5 lock-off
    tag = "R5";
    step(3);
    latch_req = 5'b00100;
    step(1);
    expect_eq("R5", "sw_en after lock fault", sw_en, 0);
    expect_eq("R1", "ss_level while off", ss_level, 0);
    latch_req = '0; vcc_at_start = 1;
    step(5);
    expect_eq("R5", "sw_en with start level while locked", sw_en, 0);
    vcc_below_uvlo = 1;
    step(3);
    expect_eq("R5", "sw_en with undervoltage while locked", sw_en, 0);
    vcc_below_uvlo = 0; vcc_below_latch_rst = 1;
    step(1);
    vcc_below_latch_rst = 0;
    step(2);
    expect_eq("R5", "sw_en after lock release", sw_en, 1);
    vcc_at_start = 0;

    // R6 undervoltage while switching is a lock-off
    tag = "R6";
    step(3);
    vcc_below_uvlo = 1;
    step(1);
    expect_eq("R6", "sw_en after undervoltage", sw_en, 0);
    vcc_below_uvlo = 0; vcc_at_start = 1;
    step(5);
    expect_eq("R6", "sw_en with start level after undervoltage", sw_en, 0);
    vcc_below_latch_rst = 1;
    step(1);
    vcc_below_latch_rst = 0;
    step(2);
    expect_eq("R6", "sw_en after lock release", sw_en, 1);
    vcc_at_start = 0;

    // R7 simultaneous faults
    tag = "R7";
    step(3);
    restart_req = 2'b01; latch_req = 5'b10000;
    step(1);
    restart_req = '0; latch_req = '0;
    expect_eq("R7", "sw_en after simultaneous faults", sw_en, 0);
    vcc_below_uvlo = 1;
    step(2);
    vcc_below_uvlo = 0; vcc_at_start = 1;
    step(4);
    expect_eq("R7", "sw_en after restart-style recharge", sw_en, 0);
    vcc_below_latch_rst = 1;
    step(1);
    vcc_below_latch_rst = 0;
    step(2);
    expect_eq("R7", "sw_en after lock release", sw_en, 1);
    vcc_at_start = 0;
    step(5);

    done = 1;
    report();
    $finish;
  end

endmodule